// File: doc/BRIEF.md
# Bit Error Rate Test Receiver with Automatic Realignment

This block is the checking side of a bit error rate tester. It takes a serial payload stream with a qualifying enable, so the stream may have gaps of any length. It aligns a local 32-bit reference generator to the incoming test pattern. The pattern may be a programmable pseudo-random sequence, a quasi-random signal source, or a repetitive word of programmable length. Once aligned, the block compares every qualified bit against the reference, and it counts the bits checked and the bits in error.

Alignment takes two phases. In the first, the reference register is filled directly from the stream. In the second, the reference runs freely and is checked against the stream. Lock is declared only when the whole check phase is clean. While locked, the mismatches within each fixed 64-bit window are totalled. When the total reaches the threshold, the block drops lock and aligns again, unless automatic realignment is switched off. A single strobe copies both counters to held outputs and restarts the live counters.

Top module: `bertrx_core`

## Requirements
- R1: Each enabled bit shifts the 32-bit reference register one place toward the high end, and the new bit enters at the low end (position 1). Pattern select 0 is pseudo-random: the feedback is the XOR of positions given by tap A and tap B (each 1 to 32). Select 1 is quasi-random: the feedback is the XOR of positions 17 and 20. Select 2 is repetitive: the feedback is position tap A, which gives a word of that length. Select 3 behaves like select 0. For selects 0, 1 and 3 the feedback is forced to one when positions 1 to 31 are all zero. For select 1, the expected bit is forced to one when it and the 13 lowest positions would all be zero. In every other case the expected bit equals the feedback.
- R2: On a clean stream, lock asserts right after the 64th enabled bit following reset or loss of lock. The first 32 bits are loaded and the next 32 are checked. Lock is still low after the 63rd bit.
- R3: A mismatch during the check phase returns the block to the load phase. A fresh 64 clean bits are then needed before lock asserts.
- R4: While locked with automatic realignment on, lock drops right after the enabled bit that brings the mismatches of the current window to 6. Windows start at lock entry and restart every 64 enabled locked bits. Six mismatches split across two windows do not drop lock.
- R5: With automatic realignment off, lock stays asserted whatever the error rate, and every mismatch is still counted.
- R6: A cycle with the enable low changes neither the lock state, nor the alignment progress, nor the counters, whatever the data input carries.
- R7: The bit counter advances once for each enabled bit received while locked, and the error counter advances once for each such bit that mismatches. Bits received while not locked are not counted, and neither is the bit on which lock is gained.
- R8: The error counter (24 bits by default) and the bit counter (32 bits by default) stop at full scale instead of wrapping.
- R9: The latch strobe loads the held outputs with the live counts as they stood before that cycle. It restarts each live counter at that cycle's own contribution (0 or 1). Without the strobe, the held outputs do not change.
- R10: Synchronous reset clears lock, both live counters and both held outputs, and restarts the load phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_rx_data | input | 1 | Received payload bit |
| i_rx_en | input | 1 | Qualifies i_rx_data for this cycle |
| i_pat_mode | input | 2 | Pattern select (0 pseudo-random, 1 quasi-random, 2 repetitive, 3 as 0) |
| i_tap_a | input | 6 | First feedback position, or repetitive word length |
| i_tap_b | input | 6 | Second feedback position (pseudo-random) |
| i_auto_resync | input | 1 | Enables automatic realignment on excess errors |
| i_latch | input | 1 | Copies counters to held outputs and restarts them |
| o_locked | output | 1 | Reference aligned to the stream |
| o_err_hold | output | ERR_W | Held error count |
| o_bit_hold | output | BIT_W | Held bit count |

## Verification
The alignment path is driven with a 9-stage and a 15-stage pseudo-random sequence, a 7-bit repetitive word and the quasi-random source, all with random gaps. Agreement on the exact lock cycle shows that the register, the taps and the load-then-check sequence are right for each feedback rule. Error bursts placed just inside one window and across a window boundary tell the window reset apart from a running total. A verify-phase error with a known restart position isolates the check-phase abort. A long random run with sparse errors, together with a second instance whose counters are narrow, compares counts, saturation and strobe timing against a reference model kept in the bench.

// File: rtl/bertrx_pkg.sv
package bertrx_pkg;

    localparam int REG_W     = 32;
    localparam int TAP_W     = 6;
    localparam int QRSS_TA   = 17;
    localparam int QRSS_TB   = 20;
    localparam int QRSS_ZRUN = 14;

    typedef enum logic [1:0] {
        PAT_PRBS   = 2'd0,
        PAT_QRSS   = 2'd1,
        PAT_REPEAT = 2'd2,
        PAT_SPARE  = 2'd3
    } pat_mode_e;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } acq_state_e;

    typedef struct packed {
        pat_mode_e          mode;
        logic [TAP_W-1:0]   tap_a;
        logic [TAP_W-1:0]   tap_b;
    } pat_cfg_t;

    typedef struct packed {
        logic count_bit;
        logic count_err;
    } tally_t;

endpackage

// File: rtl/bertrx_refgen.sv
module bertrx_refgen
    import bertrx_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int QA = QRSS_TA,
    parameter int QB = QRSS_TB,
    parameter int QZ = QRSS_ZRUN
) (
    input  logic     clk,
    input  logic     rst,
    input  pat_cfg_t cfg,
    input  logic     load_en,
    input  logic     advance_en,
    input  logic     data_in,
    output logic     expect_bit
);

    localparam int IW = $clog2(W);

    function automatic logic [IW-1:0] tap_pos(input logic [TAP_W-1:0] t);
        if (t == '0)
            return '0;
        if (int'(t) > W)
            return IW'(W - 1);
        return IW'(t - 1'b1);
    endfunction

    logic [W-1:0] sr;
    logic         fb_raw;
    logic         fb;
    logic         body_zero;

    always_comb begin
        case (cfg.mode)
            PAT_QRSS:   fb_raw = sr[QA-1] ^ sr[QB-1];
            PAT_REPEAT: fb_raw = sr[tap_pos(cfg.tap_a)];
            default:    fb_raw = sr[tap_pos(cfg.tap_a)] ^ sr[tap_pos(cfg.tap_b)];
        endcase
        body_zero = (sr[W-2:0] == '0);
        fb = (cfg.mode != PAT_REPEAT && body_zero) ? 1'b1 : fb_raw;
        expect_bit = fb;
        if (cfg.mode == PAT_QRSS && {sr[QZ-2:0], fb} == '0)
            expect_bit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (load_en)
            sr <= {sr[W-2:0], data_in};
        else if (advance_en)
            sr <= {sr[W-2:0], fb};
    end

endmodule

// File: rtl/bertrx_acq.sv
module bertrx_acq
    import bertrx_pkg::*;
#(
    parameter int W       = REG_W,
    parameter int WIN_LEN = 64,
    parameter int THRESH  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       data_in,
    input  logic       expect_bit,
    input  logic       auto_resync,
    output logic       load_en,
    output logic       advance_en,
    output logic       locked,
    output tally_t     tally
);

    localparam int PH_W  = $clog2(W);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int WE_W  = $clog2(WIN_LEN + 1);

    acq_state_e        state;
    logic [PH_W-1:0]   phase_cnt;
    logic [WIN_W-1:0]  win_cnt;
    logic [WE_W-1:0]   win_err;
    logic [WE_W-1:0]   win_err_next;
    logic              mismatch;

    assign mismatch     = data_in ^ expect_bit;
    assign win_err_next = win_err + WE_W'(mismatch);
    assign load_en      = bit_en && (state == ST_LOAD);
    assign advance_en   = bit_en && (state != ST_LOAD);
    assign locked       = (state == ST_LOCKED);

    always_comb begin
        tally.count_bit = bit_en && (state == ST_LOCKED);
        tally.count_err = tally.count_bit && mismatch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_LOAD;
            phase_cnt <= '0;
            win_cnt   <= '0;
            win_err   <= '0;
        end else if (bit_en) begin
            case (state)
                ST_LOAD: begin
                    if (phase_cnt == PH_W'(W - 1)) begin
                        state     <= ST_VERIFY;
                        phase_cnt <= '0;
                    end else begin
                        phase_cnt <= phase_cnt + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (mismatch) begin
                        state     <= ST_LOAD;
                        phase_cnt <= '0;
                    end else if (phase_cnt == PH_W'(W - 1)) begin
                        state     <= ST_LOCKED;
                        phase_cnt <= '0;
                        win_cnt   <= '0;
                        win_err   <= '0;
                    end else begin
                        phase_cnt <= phase_cnt + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (auto_resync && win_err_next >= WE_W'(THRESH)) begin
                        state     <= ST_LOAD;
                        phase_cnt <= '0;
                    end else if (win_cnt == WIN_W'(WIN_LEN - 1)) begin
                        win_cnt <= '0;
                        win_err <= '0;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                        win_err <= win_err_next;
                    end
                end
                default: begin
                    state     <= ST_LOAD;
                    phase_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bertrx_tally.sv
module bertrx_tally #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          latch,
    output logic [CW-1:0] live,
    output logic [CW-1:0] hold
);

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            hold <= '0;
        end else if (latch) begin
            hold <= live;
            live <= CW'(inc);
        end else if (inc && live != '1) begin
            live <= live + 1'b1;
        end
    end

endmodule

// File: rtl/bertrx_core.sv
module bertrx_core
    import bertrx_pkg::*;
#(
    parameter int ERR_W   = 24,
    parameter int BIT_W   = 32,
    parameter int WIN_LEN = 64,
    parameter int THRESH  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             i_rx_data,
    input  logic             i_rx_en,
    input  logic [1:0]       i_pat_mode,
    input  logic [TAP_W-1:0] i_tap_a,
    input  logic [TAP_W-1:0] i_tap_b,
    input  logic             i_auto_resync,
    input  logic             i_latch,
    output logic             o_locked,
    output logic [ERR_W-1:0] o_err_hold,
    output logic [BIT_W-1:0] o_bit_hold
);

    pat_cfg_t         cfg;
    tally_t           tally;
    logic             load_en;
    logic             advance_en;
    logic             expect_bit;
    logic [ERR_W-1:0] err_live;
    logic [BIT_W-1:0] bit_live;

    assign cfg.mode  = pat_mode_e'(i_pat_mode);
    assign cfg.tap_a = i_tap_a;
    assign cfg.tap_b = i_tap_b;

    bertrx_refgen #(
        .W (REG_W)
    ) u_refgen (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .load_en    (load_en),
        .advance_en (advance_en),
        .data_in    (i_rx_data),
        .expect_bit (expect_bit)
    );

    bertrx_acq #(
        .W       (REG_W),
        .WIN_LEN (WIN_LEN),
        .THRESH  (THRESH)
    ) u_acq (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (i_rx_en),
        .data_in     (i_rx_data),
        .expect_bit  (expect_bit),
        .auto_resync (i_auto_resync),
        .load_en     (load_en),
        .advance_en  (advance_en),
        .locked      (o_locked),
        .tally       (tally)
    );

    bertrx_tally #(
        .CW (ERR_W)
    ) u_err_tally (
        .clk   (clk),
        .rst   (rst),
        .inc   (tally.count_err),
        .latch (i_latch),
        .live  (err_live),
        .hold  (o_err_hold)
    );

    bertrx_tally #(
        .CW (BIT_W)
    ) u_bit_tally (
        .clk   (clk),
        .rst   (rst),
        .inc   (tally.count_bit),
        .latch (i_latch),
        .live  (bit_live),
        .hold  (o_bit_hold)
    );

endmodule

// File: rtl/bertrx_chk.sv
module bertrx_chk #(
    parameter int ERR_W = 24,
    parameter int BIT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             i_rx_en,
    input logic             i_latch,
    input logic             i_auto_resync,
    input logic             o_locked,
    input logic [ERR_W-1:0] o_err_hold,
    input logic [BIT_W-1:0] o_bit_hold,
    input logic [ERR_W-1:0] err_live,
    input logic [BIT_W-1:0] bit_live
);

    AST_LOCK_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(o_locked) |-> $past(i_rx_en)); // R2

    AST_GAP_KEEPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        !i_rx_en |=> $stable(o_locked)); // R6

    AST_GAP_KEEPS_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (!i_rx_en && !i_latch) |=> ($stable(bit_live) && $stable(err_live))); // R6

    AST_UNLOCKED_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!o_locked && !i_latch) |=> $stable(bit_live)); // R7

    AST_MANUAL_HOLDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (o_locked && !i_auto_resync) |=> o_locked); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (bit_live == '1 && !i_latch) |=> (bit_live == '1)); // R8

    AST_NO_ERR_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (err_live == '1 && !i_latch) |=> (err_live == '1)); // R8

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !i_latch |=> ($stable(o_err_hold) && $stable(o_bit_hold))); // R9

    AST_LATCH_RESTART: assert property (@(posedge clk) disable iff (rst)
        i_latch |=> (bit_live <= BIT_W'(1) && err_live <= ERR_W'(1))); // R9

endmodule

bind bertrx_core bertrx_chk #(
    .ERR_W (ERR_W),
    .BIT_W (BIT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .i_rx_en       (i_rx_en),
    .i_latch       (i_latch),
    .i_auto_resync (i_auto_resync),
    .o_locked      (o_locked),
    .o_err_hold    (o_err_hold),
    .o_bit_hold    (o_bit_hold),
    .err_live      (err_live),
    .bit_live      (bit_live)
);

// File: tb/bertrx_core_tb.sv
module bertrx_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_data = 1'b0;
    logic        rx_en = 1'b0;
    logic [1:0]  pat_mode = 2'd0;
    logic [5:0]  tap_a = 6'd9;
    logic [5:0]  tap_b = 6'd5;
    logic        auto_rs = 1'b1;
    logic        latch = 1'b0;
    logic        locked;
    logic [23:0] err_hold;
    logic [31:0] bit_hold;
    logic        s_locked;
    logic [3:0]  s_err_hold;
    logic [5:0]  s_bit_hold;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench reference model state
    logic [31:0] txr;
    int st, cnt, win, werr;
    longint m_bits, m_errs;
    bit gaps = 1;

    always #5 clk = ~clk;

    bertrx_core u_dut (
        .clk(clk), .rst(rst), .i_rx_data(rx_data), .i_rx_en(rx_en),
        .i_pat_mode(pat_mode), .i_tap_a(tap_a), .i_tap_b(tap_b),
        .i_auto_resync(auto_rs), .i_latch(latch),
        .o_locked(locked), .o_err_hold(err_hold), .o_bit_hold(bit_hold)
    );

    bertrx_core #(.ERR_W(4), .BIT_W(6)) u_dut_small (
        .clk(clk), .rst(rst), .i_rx_data(rx_data), .i_rx_en(rx_en),
        .i_pat_mode(pat_mode), .i_tap_a(tap_a), .i_tap_b(tap_b),
        .i_auto_resync(auto_rs), .i_latch(latch),
        .o_locked(s_locked), .o_err_hold(s_err_hold), .o_bit_hold(s_bit_hold)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input logic d, input logic en, input logic lat);
        @(negedge clk);
        rx_data = d;
        rx_en   = en;
        latch   = lat;
        @(posedge clk);
        #2;
    endtask

    // transmit-side pattern rule, written from R1
    task automatic tx_step(output logic e);
        logic fb;
        case (pat_mode)
            2'd1:    fb = txr[16] ^ txr[19];
            2'd2:    fb = txr[tap_a - 1];
            default: fb = txr[tap_a - 1] ^ txr[tap_b - 1];
        endcase
        if (pat_mode != 2'd2 && txr[30:0] == 31'd0) fb = 1'b1;
        e = fb;
        if (pat_mode == 2'd1 && {txr[12:0], fb} == 14'd0) e = 1'b1;
        txr = {txr[30:0], fb};
    endtask

    // acquisition / window / counter model from R2..R9
    task automatic model(input bit err);
        if (st == 0) begin
            cnt++;
            if (cnt == 32) begin st = 1; cnt = 0; end
        end else if (st == 1) begin
            if (err) begin st = 0; cnt = 0; end
            else begin
                cnt++;
                if (cnt == 32) begin st = 2; cnt = 0; win = 0; werr = 0; end
            end
        end else begin
            m_bits++;
            m_errs += err;
            werr += err;
            if (auto_rs && werr >= 6) begin st = 0; cnt = 0; end
            else begin
                win++;
                if (win == 64) begin win = 0; werr = 0; end
            end
        end
    endtask

    task automatic send(input bit err, input bit lat);
        logic e;
        longint eb, ee;
        if (gaps)
            while ($urandom_range(0, 3) == 0)
                tick(1'($urandom_range(0, 1)), 1'b0, 1'b0);
        tx_step(e);
        eb = m_bits;
        ee = m_errs;
        if (lat) begin m_bits = 0; m_errs = 0; end
        model(err);
        tick(e ^ err, 1'b1, lat);
        if (lat) begin
            check("R9 held bits on enabled-bit latch", bit_hold, eb);
            check("R9 held errors on enabled-bit latch", err_hold, ee);
        end
    endtask

    task automatic latch_check(input string tag);
        tick(1'($urandom_range(0, 1)), 1'b0, 1'b1);
        check({tag, " bits"}, bit_hold, m_bits);
        check({tag, " errors"}, err_hold, m_errs);
        m_bits = 0;
        m_errs = 0;
    endtask

    task automatic restart(input logic [1:0] mode, input logic [5:0] a,
                           input logic [5:0] b, input logic [31:0] seed);
        logic e;
        rst = 1'b1;
        tick(1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
        pat_mode = mode;
        tap_a = a;
        tap_b = b;
        txr = seed;
        for (int i = 0; i < 40; i++) tx_step(e);
        st = 0; cnt = 0; win = 0; werr = 0; m_bits = 0; m_errs = 0;
        check("R10 reset clears lock", locked, 0);
        check("R10 reset clears held bits", bit_hold, 0);
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0B17));

        // R10: reset state
        tick(1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
        check("R10 lock low in reset", locked, 0);
        check("R10 held errors zero", err_hold, 0);
        check("R10 held bits zero", bit_hold, 0);

        // R1 R2: 9-stage pseudo-random, exact lock cycle
        restart(2'd0, 6'd9, 6'd5, 32'h1357_9BDF);
        for (int i = 0; i < 63; i++) send(0, 0);
        check("R2 lock still low after 63 bits", locked, 0);
        send(0, 0);
        check("R2 lock after 64 bits", locked, 1);
        latch_check("R7 lock-gaining bit not counted");

        // R6 R7: clean traffic with a long noisy gap
        for (int i = 0; i < 70; i++) send(0, 0);
        for (int i = 0; i < 12; i++) tick(1'($urandom_range(0, 1)), 1'b0, 1'b0);
        for (int i = 0; i < 80; i++) send(0, 0);
        check("R6 lock kept over gap", locked, 1);
        latch_check("R6 R7 clean count");

        // R9: latch coinciding with an enabled bit
        for (int i = 0; i < 10; i++) send(0, 0);
        send(0, 1);
        latch_check("R9 restart from latching bit");

        // R4: six errors split across a window boundary
        while (win != 61) send(0, 0);
        for (int i = 0; i < 6; i++) send(1, 0);
        for (int i = 0; i < 20; i++) send(0, 0);
        check("R4 split errors keep lock", locked, 1);
        latch_check("R7 split error count");

        // R4: five errors inside one window keep lock, sixth drops it
        while (win != 0) send(0, 0);
        for (int i = 0; i < 40; i++) send(i % 4 == 0 && i < 20, 0);
        check("R4 five errors keep lock", locked, 1);
        while (win != 0) send(0, 0);
        for (int i = 0; i < 25; i++) send(i % 5 == 0, 0);
        check("R4 lock held before sixth error", locked, 1);
        send(1, 0);
        check("R4 lock dropped at sixth error", locked, 0);
        latch_check("R7 errors up to drop");

        // R3: check-phase mismatch restarts loading
        for (int i = 0; i < 39; i++) send(0, 0);
        send(1, 0);
        for (int i = 0; i < 63; i++) send(0, 0);
        check("R3 no lock before fresh 64", locked, 0);
        send(0, 0);
        check("R3 lock after fresh 64", locked, 1);
        latch_check("R7 nothing counted while aligning");

        // R5 R8: automatic realignment off, heavy errors; narrow counters saturate
        auto_rs = 1'b0;
        for (int i = 0; i < 90; i++) send(i % 3 == 0, 0);
        check("R5 lock held with realignment off", locked, 1);
        tick(1'b0, 1'b0, 1'b1);
        check("R5 all errors counted", err_hold, 30);
        check("R5 all bits counted", bit_hold, 90);
        check("R8 narrow error counter saturates", s_err_hold, 15);
        check("R8 narrow bit counter saturates", s_bit_hold, 63);
        m_bits = 0; m_errs = 0;
        auto_rs = 1'b1;

        // R1: repetitive 7-bit word
        restart(2'd2, 6'd7, 6'd1, 32'h0000_005B);
        for (int i = 0; i < 63; i++) send(0, 0);
        check("R1 R2 repetitive low after 63", locked, 0);
        send(0, 0);
        check("R1 repetitive locks at 64", locked, 1);
        for (int i = 0; i < 100; i++) send(0, 0);
        latch_check("R1 repetitive error-free");

        // R1: select 3 behaves as pseudo-random, 15 stages
        restart(2'd3, 6'd15, 6'd14, 32'h00C0_FFEE);
        for (int i = 0; i < 64; i++) send(0, 0);
        check("R1 spare select locks", locked, 1);
        for (int i = 0; i < 150; i++) send(0, 0);
        latch_check("R1 spare select error-free");

        // R1: quasi-random source
        restart(2'd1, 6'd1, 6'd1, 32'h9E37_79B9);
        for (int i = 0; i < 64; i++) send(0, 0);
        check("R1 quasi-random locks", locked, 1);
        for (int i = 0; i < 300; i++) send(0, 0);
        latch_check("R1 quasi-random error-free");

        // random run: 23-stage sequence, sparse errors, model comparison
        restart(2'd0, 6'd23, 6'd18, 32'h2468_ACE1);
        for (int blk = 0; blk < 8; blk++) begin
            for (int i = 0; i < 300; i++)
                send(st != 0 && $urandom_range(0, 39) == 0, 0);
            check("R4 R7 random lock state", locked, st == 2);
            latch_check("R7 random counts");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule